// File: doc/BRIEF.md
# Destination Address Remapper

This block rewrites the 32-bit destination address of a packet on its way through a link endpoint. A two-bit mode, presented with each packet, chooses how the address is rewritten. Pass-through leaves it alone. Static substitution overwrites chosen bits of the upper 12-bit window (bits 31:20) with a pattern. Dynamic relocation removes the column position from the address and adds a 32-bit base offset. The rest of the packet is carried beside the address without change.

The result is registered. A packet presented with `valid_i` high in one cycle appears on the outputs in the next cycle, with `valid_o` high. A parameter builds the transmit-side variant instead. In that variant, mode 01 spreads address bits 17:16 into a two-bit field, and the other mode values pass the address through. The mask, pattern, column and offset inputs are quasi-static configuration. They are sampled in the same cycle as the packet.

Top module: `dst_addr_remap`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is 0 and `addr_o` and `payload_o` are all zeros.
- R2: Mode 2'b00 gives an output address equal to the input address.
- R3: In mode 2'b01 on the receive variant (TX_VARIANT=0), output bits 31:20 are `(sel_i & pattern_i) | (~sel_i & addr_i[31:20])`, and bits 19:0 equal the input.
- R4: In mode 2'b10 on the receive variant, the output is `addr_i - (colid_i << 20) + offset_i`. The arithmetic wraps modulo 2^32, and `colid_i` is 6 bits wide.
- R5: In mode 2'b11 on the receive variant, the output address equals the input address.
- R6: `valid_o` is `valid_i` delayed by exactly one clock. Packets presented on consecutive cycles, with any mix of modes, come out on consecutive cycles in the same order.
- R7: `payload_o` equals the `payload_i` that was presented with the packet now on the output.
- R8: In mode 2'b01 on the transmit variant (TX_VARIANT=1), the output is `{addr_i[29:16], (addr_i[17]|addr_i[16]) ? 2'b11 : 2'b00, addr_i[15:0]}`.
- R9: In modes 2'b10 and 2'b11 on the transmit variant, the output address equals the input address.
- R10: In a cycle where `valid_i` is low, the inputs are ignored. `addr_o` and `payload_o` keep the last packet's values, and `valid_o` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Packet present this cycle |
| mode_i | input | 2 | Remap mode for this packet |
| addr_i | input | ADDR_W | Destination address in |
| payload_i | input | PAYLOAD_W | Remaining packet fields, carried unchanged |
| sel_i | input | HI_W | Static mode bit-select mask for the upper window |
| pattern_i | input | HI_W | Static mode replacement bits |
| colid_i | input | COL_W | Column position removed in dynamic mode |
| offset_i | input | ADDR_W | Base offset added in dynamic mode |
| valid_o | output | 1 | Remapped packet present |
| addr_o | output | ADDR_W | Remapped destination address |
| payload_o | output | PAYLOAD_W | Remaining packet fields |

## Verification
In any one cycle the block both shows the previous packet's result and loads the next packet, whose mode can differ.

The bench exercises this overlap by driving long back-to-back runs in which the mode changes on every beat. One run moves from static to dynamic to reserved to pass-through. Another places wrapping dynamic cases directly after static ones.

A monitor pops the queued expectation for each output beat. It compares the address and the payload together, so a result loaded under the wrong mode, or a beat that is lost or duplicated, shows as a mismatch at that exact position. A second instance, built as the transmit variant, receives the same stimulus and has its own queue.

// File: rtl/remap_pkg.sv
package remap_pkg;
  typedef enum logic [1:0] {
    MODE_PASS    = 2'b00,
    MODE_STATIC  = 2'b01,
    MODE_DYNAMIC = 2'b10,
    MODE_RSVD    = 2'b11
  } remap_mode_e;
endpackage

// File: rtl/remap_static.sv
module remap_static #(
  parameter int ADDR_W = 32,
  parameter int HI_W   = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [HI_W-1:0]   sel_i,
  input  logic [HI_W-1:0]   pattern_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int LO_W = ADDR_W - HI_W;

  logic [HI_W-1:0] hi_in;

  assign hi_in  = addr_i[ADDR_W-1:LO_W];
  assign addr_o = {(sel_i & pattern_i) | (~sel_i & hi_in), addr_i[LO_W-1:0]};
endmodule

// File: rtl/remap_dynamic.sv
module remap_dynamic #(
  parameter int ADDR_W    = 32,
  parameter int COL_W     = 6,
  parameter int COL_SHIFT = 20
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [COL_W-1:0]  colid_i,
  input  logic [ADDR_W-1:0] offset_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int PAD_W = ADDR_W - COL_W;

  logic [ADDR_W-1:0] col_term;

  // modulo 2^ADDR_W by width truncation
  assign col_term = {{PAD_W{1'b0}}, colid_i} << COL_SHIFT;
  assign addr_o   = addr_i - col_term + offset_i;
endmodule

// File: rtl/remap_spread.sv
module remap_spread #(
  parameter int ADDR_W = 32,
  parameter int SPLIT  = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [1:0] pair;

  assign pair   = (|addr_i[SPLIT+1:SPLIT]) ? 2'b11 : 2'b00;
  assign addr_o = {addr_i[ADDR_W-3:SPLIT], pair, addr_i[SPLIT-1:0]};
endmodule

// File: rtl/dst_addr_remap.sv
module dst_addr_remap
  import remap_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int HI_W       = 12,
  parameter int COL_W      = 6,
  parameter int PAYLOAD_W  = 72,
  parameter bit TX_VARIANT = 1'b0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [1:0]           mode_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [PAYLOAD_W-1:0] payload_i,
  input  logic [HI_W-1:0]      sel_i,
  input  logic [HI_W-1:0]      pattern_i,
  input  logic [COL_W-1:0]     colid_i,
  input  logic [ADDR_W-1:0]    offset_i,
  output logic                 valid_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [PAYLOAD_W-1:0] payload_o
);
  localparam int LO_W = ADDR_W - HI_W;

  logic [ADDR_W-1:0]    addr_nxt;
  logic                 valid_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [PAYLOAD_W-1:0] pay_q;

  if (TX_VARIANT) begin : g_tx
    logic [ADDR_W-1:0] spread_addr;

    remap_spread #(.ADDR_W(ADDR_W), .SPLIT(16)) u_spread (
      .addr_i(addr_i),
      .addr_o(spread_addr)
    );

    // reserved 1x codes fall back to pass-through
    always_comb addr_nxt = (mode_i == MODE_STATIC) ? spread_addr : addr_i;

    assert_tx_spread_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o && $past(mode_i) == MODE_STATIC |->
        addr_o[15:0] == $past(addr_i[15:0]) &&
        addr_o[17:16] == {2{$past(|addr_i[17:16])}} &&
        addr_o[ADDR_W-1:18] == $past(addr_i[ADDR_W-3:16]));

    assert_tx_rsvd_pass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o && $past(mode_i[1]) |-> addr_o == $past(addr_i));
  end else begin : g_rx
    logic [ADDR_W-1:0] static_addr;
    logic [ADDR_W-1:0] dyn_addr;

    remap_static #(.ADDR_W(ADDR_W), .HI_W(HI_W)) u_static (
      .addr_i   (addr_i),
      .sel_i    (sel_i),
      .pattern_i(pattern_i),
      .addr_o   (static_addr)
    );

    remap_dynamic #(.ADDR_W(ADDR_W), .COL_W(COL_W), .COL_SHIFT(LO_W)) u_dynamic (
      .addr_i  (addr_i),
      .colid_i (colid_i),
      .offset_i(offset_i),
      .addr_o  (dyn_addr)
    );

    always_comb begin
      case (remap_mode_e'(mode_i))
        MODE_STATIC:  addr_nxt = static_addr;
        MODE_DYNAMIC: addr_nxt = dyn_addr;
        default:      addr_nxt = addr_i;
      endcase
    end

    assert_static_mask_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o && $past(mode_i) == MODE_STATIC |->
        addr_o[LO_W-1:0] == $past(addr_i[LO_W-1:0]) &&
        (addr_o[ADDR_W-1:LO_W] & $past(sel_i)) == $past(sel_i & pattern_i) &&
        (addr_o[ADDR_W-1:LO_W] & ~$past(sel_i)) == $past(addr_i[ADDR_W-1:LO_W] & ~sel_i));

    assert_dynamic_sum_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o && $past(mode_i) == MODE_DYNAMIC |->
        ADDR_W'(addr_o + ({{(ADDR_W-COL_W){1'b0}}, $past(colid_i)} << LO_W))
          == ADDR_W'($past(addr_i) + $past(offset_i)));

    assert_rsvd_pass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o && $past(mode_i) == MODE_RSVD |-> addr_o == $past(addr_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      pay_q   <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        addr_q <= addr_nxt;
        pay_q  <= payload_i;
      end
    end
  end

  assign valid_o   = valid_q;
  assign addr_o    = addr_q;
  assign payload_o = pay_q;

  assert_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(mode_i) == MODE_PASS |-> addr_o == $past(addr_i));

  assert_valid_delay_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  assert_payload_carry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> payload_o == $past(payload_i));

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(addr_o) && $stable(payload_o));
endmodule

// File: tb/dst_addr_remap_tb_top.sv
`timescale 1ns/1ps
module dst_addr_remap_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic [31:0] addr_i = '0;
  logic [71:0] payload_i = '0;
  logic [11:0] sel_i = '0;
  logic [11:0] pattern_i = '0;
  logic [5:0]  colid_i = '0;
  logic [31:0] offset_i = '0;

  logic        rx_valid, tx_valid;
  logic [31:0] rx_addr, tx_addr;
  logic [71:0] rx_pay, tx_pay;

  int checks = 0;
  int errors = 0;
  int seq = 0;
  bit done = 1'b0;
  logic [31:0] last_rx, last_tx;
  logic [71:0] last_pay;

  typedef struct {
    logic [31:0] addr;
    logic [71:0] pay;
    string       tag;
  } item_t;
  item_t rx_q[$];
  item_t tx_q[$];

  always #2.5 clk = ~clk;

  dst_addr_remap #(.TX_VARIANT(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .mode_i(mode_i),
    .addr_i(addr_i), .payload_i(payload_i), .sel_i(sel_i), .pattern_i(pattern_i),
    .colid_i(colid_i), .offset_i(offset_i),
    .valid_o(rx_valid), .addr_o(rx_addr), .payload_o(rx_pay)
  );

  dst_addr_remap #(.TX_VARIANT(1'b1)) dut_tx_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .mode_i(mode_i),
    .addr_i(addr_i), .payload_i(payload_i), .sel_i(sel_i), .pattern_i(pattern_i),
    .colid_i(colid_i), .offset_i(offset_i),
    .valid_o(tx_valid), .addr_o(tx_addr), .payload_o(tx_pay)
  );

  function automatic logic [31:0] exp_rx(input logic [1:0] m, input logic [31:0] a,
      input logic [11:0] s, input logic [11:0] p, input logic [5:0] c, input logic [31:0] o);
    logic [31:0] r;
    case (m)
      2'b01:   r = {(s & p) | (~s & a[31:20]), a[19:0]};
      2'b10:   r = a - (32'(c) * 32'h0010_0000) + o;
      default: r = a;
    endcase
    return r;
  endfunction

  function automatic logic [31:0] exp_tx(input logic [1:0] m, input logic [31:0] a);
    if (m == 2'b01) return {a[29:16], (a[17] | a[16]) ? 2'b11 : 2'b00, a[15:0]};
    return a;
  endfunction

  task automatic check(input string tag, input bit ok, input logic [31:0] act_a,
      input logic [31:0] exp_a, input logic [71:0] act_p, input logic [71:0] exp_p);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: addr act=%h exp=%h payload act=%h exp=%h",
               tag, act_a, exp_a, act_p, exp_p);
    end
  endtask

  // driver: called at a negedge, leaves one beat on the inputs
  task automatic send(input logic [1:0] m, input logic [31:0] a, input logic [11:0] s,
      input logic [11:0] p, input logic [5:0] c, input logic [31:0] o,
      input string rtag, input string ttag);
    item_t ri, ti;
    logic [71:0] pay;
    seq++;
    pay = {8'(seq), ~a, a};
    ri.addr = exp_rx(m, a, s, p, c, o); ri.pay = pay; ri.tag = {rtag, "/R6/R7 rx"};
    ti.addr = exp_tx(m, a);             ti.pay = pay; ti.tag = {ttag, "/R6/R7 tx"};
    rx_q.push_back(ri);
    tx_q.push_back(ti);
    last_rx = ri.addr; last_tx = ti.addr; last_pay = pay;
    valid_i = 1'b1; mode_i = m; addr_i = a; payload_i = pay;
    sel_i = s; pattern_i = p; colid_i = c; offset_i = o;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    valid_i = 1'b0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: scoreboard compare on every output beat
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rx_valid) begin
        if (rx_q.size() == 0) check("R6 rx unexpected beat", 1'b0, rx_addr, 32'h0, rx_pay, 72'h0);
        else begin
          item_t it;
          it = rx_q.pop_front();
          check(it.tag, rx_addr == it.addr && rx_pay == it.pay, rx_addr, it.addr, rx_pay, it.pay);
        end
      end
      if (tx_valid) begin
        if (tx_q.size() == 0) check("R6 tx unexpected beat", 1'b0, tx_addr, 32'h0, tx_pay, 72'h0);
        else begin
          item_t it;
          it = tx_q.pop_front();
          check(it.tag, tx_addr == it.addr && tx_pay == it.pay, tx_addr, it.addr, tx_pay, it.pay);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rx", !rx_valid && rx_addr == 0 && rx_pay == 0, rx_addr, 32'h0, rx_pay, 72'h0);
    check("R1 tx", !tx_valid && tx_addr == 0 && tx_pay == 0, tx_addr, 32'h0, tx_pay, 72'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: pass-through
    send(2'b00, 32'h8080_0000, 12'hFFF, 12'h123, 6'd5, 32'h1111_0000, "R2", "R2");
    send(2'b00, 32'hFFFF_FFFF, 12'hFFF, 12'h000, 6'd63, 32'h0, "R2", "R2");
    send(2'b00, 32'h0003_0000, 12'h0, 12'h0, 6'd0, 32'h0, "R2", "R2");
    idle(2);

    // R3 rx / R8 tx: static and spread, bits 17:16 = 01, 00, 10, 11
    send(2'b01, 32'h8081_2345, 12'hFFF, 12'hABC, 6'd1, 32'h0, "R3", "R8");
    send(2'b01, 32'h1230_4567, 12'h000, 12'hABC, 6'd1, 32'h0, "R3", "R8");
    send(2'b01, 32'h5A5A_89AB, 12'h0F0, 12'h3C3, 6'd1, 32'h0, "R3", "R8");
    send(2'b01, 32'hC003_FFFF, 12'hF0F, 12'h555, 6'd1, 32'h0, "R3", "R8");
    idle(1);

    // R4 rx / R9 tx: dynamic, incl. wrap below zero and above 2^32
    send(2'b10, 32'h8080_0010, 12'h0, 12'h0, 6'd8, 32'h1000_0000, "R4", "R9");
    send(2'b10, 32'h0010_0000, 12'h0, 12'h0, 6'd63, 32'h0, "R4 wrap-low", "R9");
    send(2'b10, 32'hFFFF_FFF0, 12'h0, 12'h0, 6'd0, 32'h0000_0020, "R4 wrap-high", "R9");
    idle(1);

    // R5 rx / R9 tx: reserved code
    send(2'b11, 32'hDEAD_BEEF, 12'hFFF, 12'hFFF, 6'd7, 32'h4444_4444, "R5", "R9");
    idle(1);

    // R6: mode changes on every beat, back to back
    send(2'b01, 32'h0102_0304, 12'hFC0, 12'hA5A, 6'd2, 32'h0800_0000, "R3", "R8");
    send(2'b10, 32'h0102_0304, 12'hFC0, 12'hA5A, 6'd2, 32'h0800_0000, "R4", "R9");
    send(2'b11, 32'h0102_0304, 12'hFC0, 12'hA5A, 6'd2, 32'h0800_0000, "R5", "R9");
    send(2'b00, 32'h0102_0304, 12'hFC0, 12'hA5A, 6'd2, 32'h0800_0000, "R2", "R2");
    send(2'b01, 32'h7FFE_0000, 12'h00F, 12'hFFF, 6'd33, 32'h0, "R3", "R8");
    send(2'b10, 32'h0000_0000, 12'h00F, 12'hFFF, 6'd33, 32'hFFFF_FFFF, "R4", "R9");

    // R10: inputs ignored while valid_i low
    valid_i = 1'b0;
    mode_i = 2'b01; addr_i = 32'h5555_5555; payload_i = '1; sel_i = 12'hFFF; pattern_i = 12'h111;
    @(negedge clk);
    @(negedge clk);
    check("R10 rx hold", !rx_valid && rx_addr == last_rx && rx_pay == last_pay,
          rx_addr, last_rx, rx_pay, last_pay);
    check("R10 tx hold", !tx_valid && tx_addr == last_tx && tx_pay == last_pay,
          tx_addr, last_tx, tx_pay, last_pay);
    idle(2);

    check("R6 rx drained", rx_q.size() == 0, 32'(rx_q.size()), 32'h0, 72'h0, 72'h0);
    check("R6 tx drained", tx_q.size() == 0, 32'(tx_q.size()), 32'h0, 72'h0, 72'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule